// File: doc/BRIEF.md
# Processor Execution Status Encoder

This block drives a 4-bit status code on every clock so that an external trace tool can follow the dynamic execution path of a processor core. The trace tool holds its own copy of the program image. The core raises one-cycle event strobes:

- an instruction starts;
- a multi-cycle instruction is still running;
- the core has switched to user level;
- a marker or debug-write opcode has started.

The encoder ranks these strobes and registers the winning code. The code is presented one clock after the strobes that produced it, and its timing does not depend on any bus transfer.

The user-level indication must follow the code of the instruction that caused it. A user-level strobe therefore only sets a pending flag. The flag is sent as its own code in the first later slot that carries no begin code and no continuation. Multi-cycle instructions emit a continuation code after their first cycle. Idle or stalled cycles emit the same code.

Top module: `exec_status_enc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status output is 0x0. Reset also clears any pending user-level indication.
- R2: A begin strobe without a marker strobe produces code 0x1 on the status output one clock later.
- R3: A marker strobe produces code 0x4 one clock later. It overrides a begin strobe given in the same cycle.
- R4: A continuation strobe with no begin or marker strobe produces code 0x0 one clock later.
- R5: A cycle with no strobes and no pending user-level indication produces code 0x0 one clock later.
- R6: A user-level strobe never changes the code of its own cycle. Code 0x3 appears at the earliest in the slot after that code.
- R7: A pending user-level indication waits while begin or marker strobes arrive. It is sent as 0x3 in the first slot that has neither.
- R8: Each pending indication produces 0x3 exactly once. A user-level strobe arriving in the cycle where 0x3 is being produced arms a new pending indication.
- R9: A pending user-level indication also waits during continuation cycles. The output stays 0x0 during those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_begin | input | 1 | First cycle of an ordinary instruction |
| ev_busy | input | 1 | Later cycle of a multi-cycle instruction |
| ev_user | input | 1 | Core has switched to user level |
| ev_marker | input | 1 | First cycle of a marker or debug-write opcode |
| status_o | output | 4 | Registered execution status code |

## Verification
Every code is due exactly one clock after the strobes that select it. The bench drives strobes on the falling edge and samples the status on the next falling edge, after one rising edge has registered it.

The user-level code is due at least two clocks after its strobe. Each wait caused by begin, marker or continuation strobes delays it by one further clock. The vector table lists the expected code for each individual slot, so a 0x3 that arrives early, late or twice fails the check for that slot.

// File: rtl/exec_status_pkg.sv
package exec_status_pkg;

    localparam int STATUS_W = 4;

    typedef logic [STATUS_W-1:0] status_t;

    localparam status_t CODE_CONT   = status_t'(4'h0);
    localparam status_t CODE_BEGIN  = status_t'(4'h1);
    localparam status_t CODE_USER   = status_t'(4'h3);
    localparam status_t CODE_MARKER = status_t'(4'h4);

    typedef struct packed {
        status_t status;
        logic    user_pend;
    } enc_state_t;

endpackage

// File: rtl/exec_code_sel.sv
module exec_code_sel
    import exec_status_pkg::*;
(
    input  logic    begin_i,
    input  logic    busy_i,
    input  logic    marker_i,
    input  logic    pend_i,
    output status_t code_o,
    output logic    user_sent_o
);

    always_comb begin
        user_sent_o = 1'b0;
        if (marker_i) begin
            code_o = CODE_MARKER;
        end else if (begin_i) begin
            code_o = CODE_BEGIN;
        end else if (pend_i && !busy_i) begin
            code_o      = CODE_USER;
            user_sent_o = 1'b1;
        end else begin
            code_o = CODE_CONT;
        end
    end

endmodule

// File: rtl/exec_user_track.sv
module exec_user_track (
    input  logic pend_q_i,
    input  logic user_i,
    input  logic sent_i,
    output logic pend_d_o
);

    always_comb begin
        pend_d_o = (pend_q_i && !sent_i) || user_i;
    end

endmodule

// File: rtl/exec_status_enc.sv
module exec_status_enc
    import exec_status_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_begin,
    input  logic                ev_busy,
    input  logic                ev_user,
    input  logic                ev_marker,
    output logic [STATUS_W-1:0] status_o
);

    enc_state_t state_d, state_q;
    status_t    sel_code;
    logic       user_sent;
    logic       pend_next;

    exec_code_sel u_sel (
        .begin_i     (ev_begin),
        .busy_i      (ev_busy),
        .marker_i    (ev_marker),
        .pend_i      (state_q.user_pend),
        .code_o      (sel_code),
        .user_sent_o (user_sent)
    );

    exec_user_track u_track (
        .pend_q_i (state_q.user_pend),
        .user_i   (ev_user),
        .sent_i   (user_sent),
        .pend_d_o (pend_next)
    );

    always_comb begin
        state_d           = state_q;
        state_d.status    = sel_code;
        state_d.user_pend = pend_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;

    // R3
    marker_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_marker |=> status_o == CODE_MARKER);

    // R2
    begin_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_begin && !ev_marker) |=> status_o == CODE_BEGIN);

    // R7 R9
    user_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_begin || ev_marker || ev_busy) |=> status_o != CODE_USER);

    // R6
    user_not_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_user && !state_q.user_pend) |=> status_o != CODE_USER);

    // R8
    user_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == CODE_USER && !$past(ev_user)) |-> !state_q.user_pend);

    // R5
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_begin && !ev_marker && !state_q.user_pend) |=> status_o == CODE_CONT);

endmodule

// File: tb/exec_status_enc_bench.sv
module exec_status_enc_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_begin, ev_busy, ev_user, ev_marker;
    logic [3:0] status_o;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    exec_status_enc u_exec_status_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_begin  (ev_begin),
        .ev_busy   (ev_busy),
        .ev_user   (ev_user),
        .ev_marker (ev_marker),
        .status_o  (status_o)
    );

    // vector: {req[3:0], begin, busy, user, marker, expected[3:0]}
    localparam int NV = 22;
    localparam logic [11:0] VEC [NV] = '{
        {4'd2, 4'b1000, 4'h1},  // R2 begin
        {4'd3, 4'b0001, 4'h4},  // R3 marker
        {4'd3, 4'b1001, 4'h4},  // R3 marker beats begin
        {4'd5, 4'b0000, 4'h0},  // R5 idle
        {4'd6, 4'b1010, 4'h1},  // R6 user with begin: own slot keeps 0x1
        {4'd6, 4'b0000, 4'h3},  // R6 user code follows
        {4'd8, 4'b0000, 4'h0},  // R8 sent once
        {4'd6, 4'b1010, 4'h1},  // R6
        {4'd9, 4'b0100, 4'h0},  // R9 waits on continuation
        {4'd4, 4'b0100, 4'h0},  // R4 continuation
        {4'd9, 4'b0000, 4'h3},  // R9 released
        {4'd6, 4'b1010, 4'h1},  // R6
        {4'd7, 4'b1000, 4'h1},  // R7 waits on begin
        {4'd7, 4'b0001, 4'h4},  // R7 waits on marker
        {4'd7, 4'b0000, 4'h3},  // R7 released
        {4'd8, 4'b0000, 4'h0},  // R8
        {4'd6, 4'b0010, 4'h0},  // R6 user alone, deferred
        {4'd6, 4'b0000, 4'h3},  // R6
        {4'd6, 4'b0010, 4'h0},  // R6
        {4'd8, 4'b0010, 4'h3},  // R8 re-armed while sending
        {4'd8, 4'b0000, 4'h3},  // R8 second indication
        {4'd8, 4'b0000, 4'h0}   // R8 cleared
    };

    task automatic check(input int req, input logic [3:0] exp);
        checks++;
        if (status_o !== exp) begin
            errors++;
            $display("FAIL R%0d: status=%h expected=%h", req, status_o, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s);
        {ev_begin, ev_busy, ev_user, ev_marker} = s;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        {ev_begin, ev_busy, ev_user, ev_marker} = 4'b1001;
        repeat (3) @(negedge clk);
        check(1, 4'h0);  // R1 held in reset
        rst_n = 1'b1;
        check(1, 4'h0);  // R1 just released

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][7:4]);
            check(int'(VEC[i][11:8]), VEC[i][3:0]);
        end

        // R1: reset discards a pending indication
        drive(4'b1010);
        check(2, 4'h1);
        rst_n = 1'b0;
        drive(4'b0000);
        check(1, 4'h0);
        rst_n = 1'b1;
        drive(4'b0000);
        check(1, 4'h0);
        drive(4'b0000);
        check(1, 4'h0);

        // R3: marker together with continuation
        drive(4'b0101);
        check(3, 4'h4);
        // R4: long continuation run
        for (int k = 0; k < 4; k++) begin
            drive(4'b0100);
            check(4, 4'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: expired=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule